// File: doc/BRIEF.md
# Multi-core interrupt distributor with acknowledge

This block collects a parameterised number of level-sensitive interrupt lines and delivers them to up to four CPUs. Every source carries a global enable bit and a routing word that names the CPUs allowed to take it. Each CPU also holds a private mask bit per source. A source is eligible for a CPU while its line is high, it is globally enabled, its routing word names that CPU and that CPU has not masked it. Each CPU's IRQ output is high while at least one source is eligible for it.

Software reaches the block through a simple single-cycle read/write bus with two register banks. The shared bank holds the identification word, the enable set and clear ports and the routing words. The per-CPU bank holds the mask set and clear ports and the acknowledge register. The CPU-select input chooses which copy of the per-CPU bank an access reaches. Enables and masks never take a bitmap. Software writes a source number to a set port or a clear port, so two CPUs can never race on a read-modify-write. Reading the acknowledge register returns the lowest-numbered source that is eligible for the selected CPU, which gives a fixed priority. Sources 0 and 1 are ordinary lines here; the system ties the summary outputs of its inter-processor and message-signalled doorbell logic to them.

Top module: `mcirq_dist`

## Requirements
- R1: After reset, every source is globally disabled, masked on every CPU and routed to no CPU. All IRQ outputs are low, every acknowledge read returns 1023 and every routing word reads 0.
- R2: A read of shared-bank offset 0x000 returns the implemented source count NSRC in bits [11:2], with all other bits zero (0x80 for 32 sources).
- R3: Writing source number n to shared-bank offset 0x030 sets the global enable of source n. Writing n to offset 0x034 clears it. A cleared source drives no IRQ and is never acknowledged.
- R4: Writing n to per-CPU offset 0x048 masks source n for the CPU on the select input. Writing n to offset 0x04C unmasks it. A mask write changes no other CPU's masks.
- R5: The routing word of source n is at shared-bank offset 0x100 + 4*n. Bit c (c < NCPU) routes the source to CPU c. Only those bits are stored; the other bits read as zero, and reads at or beyond offset 0x100 + 4*NSRC return 0.
- R6: A read of per-CPU offset 0x044 returns in bits [9:0] the lowest-numbered source eligible for the selected CPU, or 1023 when none is eligible, with bits [31:10] zero. The read changes no state, so repeated reads return the same value.
- R7: irq_o[c] is high in the cycle after a cycle in which some source was eligible for CPU c, and low in the cycle after a cycle in which none was.
- R8: Sources are level sensitive: once a source line falls, it stops being eligible at once and is not remembered.
- R9: A set or clear write to an enable or mask port whose full 32-bit data value is NSRC or more changes nothing.
- R10: Read data appears on rdata_o in the cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level-sensitive source lines; bit 0 and bit 1 carry the doorbell summaries |
| cpu_sel_i | input | CPU_W | Index of the CPU whose per-CPU bank is accessed |
| bank_i | input | 1 | 0 selects the shared bank, 1 selects the per-CPU bank |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle |
| addr_i | input | 12 | Byte offset within the selected bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NCPU | Registered per-CPU interrupt request |

## Verification
The assertions check on every cycle that the outputs are quiet after reset and that no IRQ follows a cycle with all lines low. On every read they check the shape of the identification and acknowledge data. They also check that out-of-range enable writes leave the enables untouched, that a mask write never touches another CPU's masks, and that read data holds between reads. Only the bench scenarios can show the decisions that depend on values. These include which source wins when several are eligible, that a mask or a routing bit reaches only its own CPU, and that dropping a line hands the acknowledge to the next source. They also include out-of-range numbers that would alias onto a real source if truncated, and how the registered IRQ outputs follow a behavioural model under random traffic.

// File: rtl/mcirq_pkg.sv
package mcirq_pkg;

    localparam int ID_W = 10;
    localparam int AW   = 12;

    localparam logic [AW-1:0] OFF_IDENT   = 12'h000;
    localparam logic [AW-1:0] OFF_EN_SET  = 12'h030;
    localparam logic [AW-1:0] OFF_EN_CLR  = 12'h034;
    localparam logic [AW-1:0] OFF_ACK     = 12'h044;
    localparam logic [AW-1:0] OFF_MSK_SET = 12'h048;
    localparam logic [AW-1:0] OFF_MSK_CLR = 12'h04C;
    localparam logic [AW-1:0] OFF_ROUTE   = 12'h100;

    localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_EN_SET,
        WOP_EN_CLR,
        WOP_MSK_SET,
        WOP_MSK_CLR,
        WOP_ROUTE
    } wop_e;

    typedef enum logic [1:0] {
        ROP_ZERO,
        ROP_IDENT,
        ROP_ROUTE,
        ROP_ACK
    } rop_e;

    typedef struct packed {
        wop_e            wop;
        rop_e            rop;
        logic [ID_W-1:0] wid;
        logic [ID_W-1:0] aid;
    } bus_dec_t;

endpackage

// File: rtl/mcirq_decode.sv
module mcirq_decode
    import mcirq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic          bank_i,
    input  logic [AW-1:0] addr_i,
    input  logic [31:0]   wdata_i,
    output bus_dec_t      dec_o
);

    logic          num_ok;
    logic          route_hit;
    logic [AW-1:0] roff;

    always_comb begin
        num_ok    = (wdata_i < 32'(NSRC));
        roff      = addr_i - OFF_ROUTE;
        route_hit = (addr_i[1:0] == 2'b00) && (addr_i >= OFF_ROUTE)
                    && ((roff >> 2) < AW'(NSRC));

        dec_o.wid = wdata_i[ID_W-1:0];
        dec_o.aid = roff[AW-1:2];
        dec_o.wop = WOP_NONE;
        dec_o.rop = ROP_ZERO;

        if (wr_en_i) begin
            if (!bank_i) begin
                if (addr_i == OFF_EN_SET && num_ok)      dec_o.wop = WOP_EN_SET;
                else if (addr_i == OFF_EN_CLR && num_ok) dec_o.wop = WOP_EN_CLR;
                else if (route_hit)                      dec_o.wop = WOP_ROUTE;
            end else begin
                if (addr_i == OFF_MSK_SET && num_ok)      dec_o.wop = WOP_MSK_SET;
                else if (addr_i == OFF_MSK_CLR && num_ok) dec_o.wop = WOP_MSK_CLR;
            end
        end

        if (rd_en_i) begin
            if (!bank_i) begin
                if (addr_i == OFF_IDENT) dec_o.rop = ROP_IDENT;
                else if (route_hit)      dec_o.rop = ROP_ROUTE;
            end else if (addr_i == OFF_ACK) begin
                dec_o.rop = ROP_ACK;
            end
        end
    end

endmodule

// File: rtl/mcirq_state.sv
module mcirq_state
    import mcirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  bus_dec_t                   dec_i,
    input  logic [CPU_W-1:0]           cpu_sel_i,
    input  logic [NCPU-1:0]            route_wr_i,
    output logic [NSRC-1:0]            en_o,
    output logic [NCPU-1:0][NSRC-1:0]  msk_o,
    output logic [NSRC-1:0][NCPU-1:0]  rt_o
);

    typedef struct packed {
        logic [NSRC-1:0]           en;
        logic [NCPU-1:0][NSRC-1:0] msk;
        logic [NSRC-1:0][NCPU-1:0] rt;
    } st_t;

    localparam st_t ST_RST = '{en: '0, msk: '1, rt: '0};

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NSRC; n++) begin
            if (dec_i.wid == ID_W'(n)) begin
                if (dec_i.wop == WOP_EN_SET) st_d.en[n] = 1'b1;
                if (dec_i.wop == WOP_EN_CLR) st_d.en[n] = 1'b0;
                for (int c = 0; c < NCPU; c++) begin
                    if (cpu_sel_i == CPU_W'(c)) begin
                        if (dec_i.wop == WOP_MSK_SET) st_d.msk[c][n] = 1'b1;
                        if (dec_i.wop == WOP_MSK_CLR) st_d.msk[c][n] = 1'b0;
                    end
                end
            end
            if (dec_i.wop == WOP_ROUTE && dec_i.aid == ID_W'(n)) begin
                st_d.rt[n] = route_wr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign msk_o = st_q.msk;
    assign rt_o  = st_q.rt;

endmodule

// File: rtl/mcirq_pick.sv
module mcirq_pick
    import mcirq_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] elig_i,
    output logic            hit_o,
    output logic [ID_W-1:0] id_o
);

    always_comb begin
        hit_o = 1'b0;
        id_o  = ID_NONE;
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (elig_i[n]) begin
                hit_o = 1'b1;
                id_o  = ID_W'(n);
            end
        end
    end

endmodule

// File: rtl/mcirq_dist.sv
module mcirq_dist
    import mcirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCPU  = 4,
    parameter int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [CPU_W-1:0] cpu_sel_i,
    input  logic             bank_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic [NCPU-1:0]  irq_o
);

    localparam logic [31:0] IDENT_WORD = 32'(NSRC) << 2;

    bus_dec_t                  dec;
    logic [NSRC-1:0]           st_en;
    logic [NCPU-1:0][NSRC-1:0] st_msk;
    logic [NSRC-1:0][NCPU-1:0] st_rt;
    logic [NCPU-1:0][NSRC-1:0] elig;
    logic [NCPU-1:0]           hit;
    logic [NCPU-1:0][ID_W-1:0] ack_id;

    mcirq_decode #(.NSRC(NSRC)) decode_i (
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .bank_i  (bank_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .dec_o   (dec)
    );

    mcirq_state #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) state_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (dec),
        .cpu_sel_i  (cpu_sel_i),
        .route_wr_i (wdata_i[NCPU-1:0]),
        .en_o       (st_en),
        .msk_o      (st_msk),
        .rt_o       (st_rt)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        always_comb begin
            for (int n = 0; n < NSRC; n++) begin
                elig[c][n] = src_i[n] & st_en[n] & ~st_msk[c][n] & st_rt[n][c];
            end
        end

        mcirq_pick #(.NSRC(NSRC)) pick_i (
            .elig_i (elig[c]),
            .hit_o  (hit[c]),
            .id_o   (ack_id[c])
        );
    end

    typedef struct packed {
        logic [NCPU-1:0] irq;
        logic [31:0]     rdata;
    } out_t;

    out_t            out_d, out_q;
    logic [NCPU-1:0] rt_rd;

    always_comb begin
        out_d     = out_q;
        out_d.irq = hit;

        rt_rd = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (dec.aid == ID_W'(n)) rt_rd = st_rt[n];
        end

        if (rd_en_i) begin
            case (dec.rop)
                ROP_IDENT: out_d.rdata = IDENT_WORD;
                ROP_ROUTE: out_d.rdata = 32'(rt_rd);
                ROP_ACK:   out_d.rdata = 32'(ack_id[cpu_sel_i]);
                default:   out_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rdata_o = out_q.rdata;
    assign irq_o   = out_q.irq;

endmodule

// File: rtl/mcirq_dist_chk.sv
module mcirq_dist_chk
    import mcirq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NSRC-1:0]           src_i,
    input logic [CPU_W-1:0]          cpu_sel_i,
    input logic                      bank_i,
    input logic                      wr_en_i,
    input logic                      rd_en_i,
    input logic [AW-1:0]             addr_i,
    input logic [31:0]               wdata_i,
    input logic [31:0]               rdata_o,
    input logic [NCPU-1:0]           irq_o,
    input logic [NSRC-1:0]           st_en,
    input logic [NCPU-1:0][NSRC-1:0] st_msk
);

    logic en_set_ok, en_any_bad, msk_wr, ack_rd, ident_rd;

    always_comb begin
        en_set_ok  = wr_en_i && !bank_i && addr_i == OFF_EN_SET && wdata_i < 32'(NSRC);
        en_any_bad = wr_en_i && !bank_i && (addr_i == OFF_EN_SET || addr_i == OFF_EN_CLR)
                     && wdata_i >= 32'(NSRC);
        msk_wr     = wr_en_i && bank_i && (addr_i == OFF_MSK_SET || addr_i == OFF_MSK_CLR);
        ack_rd     = rd_en_i && bank_i && addr_i == OFF_ACK;
        ident_rd   = rd_en_i && !bank_i && addr_i == OFF_IDENT;
    end

    // R1: outputs quiet in the cycle after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> irq_o == '0);

    assert_ident_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ident_rd) |-> rdata_o == (32'(NSRC) << 2));

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && en_set_ok) |-> |(st_en & (NSRC'(1) << $past(wdata_i[ID_W-1:0]))));

    for (genvar c = 0; c < NCPU; c++) begin : g_mchk
        assert_mask_private_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && msk_wr && cpu_sel_i != CPU_W'(c)) |-> st_msk[c] == $past(st_msk[c]));
    end

    assert_ack_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ack_rd) |->
            (rdata_o[31:ID_W] == '0 &&
             (rdata_o[ID_W-1:0] < ID_W'(NSRC) || rdata_o[ID_W-1:0] == ID_NONE)));

    assert_no_line_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && src_i == '0) |-> irq_o == '0);

    assert_range_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && en_any_bad) |-> st_en == $past(st_en));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !rd_en_i) |-> $stable(rdata_o));

endmodule

bind mcirq_dist mcirq_dist_chk #(.NSRC(NSRC), .NCPU(NCPU), .CPU_W(CPU_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .cpu_sel_i (cpu_sel_i),
    .bank_i    (bank_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .st_en     (st_en),
    .st_msk    (st_msk)
);

// File: tb/mcirq_dist_tb_top.sv
`timescale 1ns/1ps
module mcirq_dist_tb_top;

    localparam int NSRC = 32;
    localparam int NCPU = 4;
    localparam int CPU_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_i = '0;
    logic [CPU_W-1:0] cpu_sel_i = '0;
    logic             bank_i = 1'b0;
    logic             wr_en_i = 1'b0;
    logic             rd_en_i = 1'b0;
    logic [11:0]      addr_i = '0;
    logic [31:0]      wdata_i = '0;
    logic [31:0]      rdata_o;
    logic [NCPU-1:0]  irq_o;

    mcirq_dist #(.NSRC(NSRC), .NCPU(NCPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .cpu_sel_i(cpu_sel_i),
        .bank_i(bank_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    int  vec = 0;
    int  mis = 0;
    bit  done = 1'b0;

    // behavioural reference state
    bit              m_en  [NSRC];
    bit              m_msk [NCPU][NSRC];
    bit [NCPU-1:0]   m_rt  [NSRC];
    logic [NCPU-1:0] exp_irq = '0;
    logic [31:0]     exp_rd  = '0;

    function automatic int m_pick(int c);
        for (int n = 0; n < NSRC; n++)
            if (src_i[n] && m_en[n] && !m_msk[c][n] && m_rt[n][c]) return n;
        return 1023;
    endfunction

    task automatic m_reset();
        for (int n = 0; n < NSRC; n++) begin
            m_en[n] = 1'b0;
            m_rt[n] = '0;
            for (int c = 0; c < NCPU; c++) m_msk[c][n] = 1'b1;
        end
        exp_irq = '0;
        exp_rd  = '0;
    endtask

    initial m_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            int a;
            int w;
            a = int'(addr_i);
            w = int'(wdata_i);
            for (int c = 0; c < NCPU; c++) exp_irq[c] = (m_pick(c) != 1023);
            if (rd_en_i) begin
                exp_rd = 0;
                if (!bank_i && a == 0) exp_rd = NSRC * 4;
                else if (!bank_i && a >= 256 && a < 256 + 4 * NSRC && a % 4 == 0)
                    exp_rd = 32'(m_rt[(a - 256) / 4]);
                else if (bank_i && a == 68) exp_rd = m_pick(int'(cpu_sel_i));
            end
            if (wr_en_i) begin
                if (!bank_i) begin
                    if (a == 48 && wdata_i < NSRC) m_en[w] = 1'b1;
                    else if (a == 52 && wdata_i < NSRC) m_en[w] = 1'b0;
                    else if (a >= 256 && a < 256 + 4 * NSRC && a % 4 == 0)
                        m_rt[(a - 256) / 4] = wdata_i[NCPU-1:0];
                end else begin
                    if (a == 72 && wdata_i < NSRC) m_msk[cpu_sel_i][w] = 1'b1;
                    else if (a == 76 && wdata_i < NSRC) m_msk[cpu_sel_i][w] = 1'b0;
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            mis++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check("R7 irq_o vs model", 32'(irq_o), 32'(exp_irq));
            check("R10 rdata_o vs model", rdata_o, exp_rd);
        end
    end

    task automatic wr(bit bk, int cpu, int a, logic [31:0] d);
        bank_i = bk; cpu_sel_i = CPU_W'(cpu); addr_i = 12'(a); wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(bit bk, int cpu, int a, output logic [31:0] d);
        bank_i = bk; cpu_sel_i = CPU_W'(cpu); addr_i = 12'(a); rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        check("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(1, 0, 'h44, d); check("R1 ack idle", d, 32'd1023);
        rd(0, 0, 'h114, d); check("R1 route cleared", d, 32'h0);
        rd(0, 0, 'h000, d); check("R2 ident word", d, 32'h80);

        wr(0, 0, 'h114, 32'h2);
        rd(0, 0, 'h114, d); check("R5 route readback", d, 32'h2);
        wr(0, 0, 'h118, 32'hFFFF_FFFF);
        rd(0, 0, 'h118, d); check("R5 route unused bits zero", d, 32'hF);
        rd(0, 0, 'h180, d); check("R5 beyond last route", d, 32'h0);

        src_i[5] = 1'b1;
        wr(0, 0, 'h30, 32'd5);
        idle(2);
        check("R4 still masked irq", 32'(irq_o), 32'h0);
        rd(1, 1, 'h44, d); check("R4 masked ack", d, 32'd1023);
        wr(1, 1, 'h4C, 32'd5);
        idle(2);
        check("R7 irq cpu1", 32'(irq_o), 32'h2);
        rd(1, 1, 'h44, d); check("R6 ack cpu1", d, 32'd5);
        rd(1, 0, 'h44, d); check("R4 cpu0 unaffected", d, 32'd1023);

        wr(0, 0, 'h10C, 32'h2);
        wr(0, 0, 'h30, 32'd3);
        wr(1, 1, 'h4C, 32'd3);
        src_i[3] = 1'b1;
        rd(1, 1, 'h44, d); check("R6 lowest wins", d, 32'd3);
        rd(1, 1, 'h44, d); check("R6 reread no side effect", d, 32'd3);

        src_i[3] = 1'b0;
        rd(1, 1, 'h44, d); check("R8 level drop", d, 32'd5);

        wr(0, 0, 'h34, 32'd5);
        rd(1, 1, 'h44, d); check("R3 cleared enable ack", d, 32'd1023);
        idle(1);
        check("R3 cleared enable irq", 32'(irq_o), 32'h0);

        wr(0, 0, 'h30, 32'd5);
        wr(0, 0, 'h34, 32'd37);
        rd(1, 1, 'h44, d); check("R9 out-of-range clear", d, 32'd5);
        wr(1, 1, 'h48, 32'd37);
        rd(1, 1, 'h44, d); check("R9 out-of-range mask", d, 32'd5);

        wr(1, 1, 'h48, 32'd5);
        rd(1, 1, 'h44, d); check("R4 mask on cpu1", d, 32'd1023);
        wr(1, 1, 'h4C, 32'd5);

        wr(0, 0, 'h114, 32'h3);
        wr(1, 0, 'h4C, 32'd5);
        idle(2);
        check("R5 route to two cpus", 32'(irq_o), 32'h3);
        rd(1, 0, 'h44, d); check("R5 ack cpu0", d, 32'd5);
        wr(0, 0, 'h114, 32'h1);
        idle(2);
        check("R5 route narrowed", 32'(irq_o), 32'h1);

        wr(0, 0, 'h100, 32'h4);
        wr(0, 0, 'h104, 32'h4);
        wr(0, 0, 'h30, 32'd0);
        wr(0, 0, 'h30, 32'd1);
        wr(1, 2, 'h4C, 32'd0);
        wr(1, 2, 'h4C, 32'd1);
        src_i[0] = 1'b1; src_i[1] = 1'b1;
        rd(1, 2, 'h44, d); check("R6 source 0 wins", d, 32'd0);
        src_i[0] = 1'b0;
        rd(1, 2, 'h44, d); check("R6 source 1 next", d, 32'd1);

        wr(0, 0, 'h17C, 32'h8);
        wr(0, 0, 'h30, 32'd31);
        wr(1, 3, 'h4C, 32'd31);
        src_i[31] = 1'b1;
        rd(1, 3, 'h44, d); check("R6 top source", d, 32'd31);
        idle(1);
        check("R7 irq cpu3", 32'(irq_o[3]), 32'h1);

        // random traffic compared against the model each cycle
        for (int i = 0; i < 600; i++) begin
            int k;
            int sel;
            k = $urandom_range(0, 9);
            sel = $urandom_range(0, 3);
            if ($urandom_range(0, 3) == 0)
                for (int n = 0; n < NSRC; n++) src_i[n] = 1'($urandom);
            case (k)
                0: wr(0, 0, 'h30, $urandom_range(0, 40));
                1: wr(0, 0, 'h34, $urandom_range(0, 40));
                2: wr(1, sel, 'h48, $urandom_range(0, 40));
                3, 4: wr(1, sel, 'h4C, $urandom_range(0, 40));
                5: wr(0, 0, 'h100 + 4 * $urandom_range(0, 33), $urandom);
                6: rd(0, 0, 'h100 + 4 * $urandom_range(0, 33), d);
                7, 8: rd(1, sel, 'h44, d);
                default: idle(1);
            endcase
        end
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            mis++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
            $finish;
        end
    end

endmodule